// File: doc/BRIEF.md
# Addressed Serial Key Interface

This block is the host-facing side of a key-matrix scanner. A controller talks to it over four wires: chip-enable, a serial clock, serial data in, and an open-drain data-out line. Each transfer begins with an 8-bit address. The address is clocked in while chip-enable is low, least significant bit first, and it is decoded when chip-enable rises. The address picks what happens during the following chip-enable-high phase: either a 16-bit control word is written, or the 30 debounced key bits are shifted out. The block takes a system clock. The serial inputs are asynchronous to it and are resynchronised before use.

The control word holds three things: the standby level of each of the six drive lines, the levels of four general-purpose outputs, and a 2-bit select. The select hands the three highest drive pins over to port use one at a time. Port 1 always has its own pin. The data-out line has a second job. Whenever chip-enable is low, it is pulled low if the scanner has flagged fresh key data that the controller has not yet read. A completed read clears that request.

The scanner, the clock source and electrical timing are outside this block. The scanner supplies a one-cycle `key_hit` strobe together with the key vector.

Top module: `kscan_serial_if`

## Requirements
- R1: While reset is asserted, and right after it, all six drive pins and `port1_out` are low, `shared_is_port` is 000, `scan_enable` is 0, `ser_dout` is 1 (released) and no request is pending.
- R2: The address is the last 8 bits sampled on rising serial-clock edges while chip-enable is low, taken LSB first, and it is decoded when chip-enable rises. 0x62 opens a control write and 0x63 opens a key read. Any other value, or fewer than 8 bits, makes the block ignore the data phase.
- R3: A control write samples one bit per rising serial-clock edge. Bit k is the k-th bit sent: bits 0-5 are drive levels 1-6, bits 8-11 are port levels 1-4, bits 14-15 form the select (bit 14 is the LSB), and bits 6, 7, 12 and 13 must be 0. The word takes effect when chip-enable falls, and only if exactly 16 bits arrived and the pad bits are 0. Any other frame leaves the outputs unchanged.
- R4: With select value s, the top s shared pins act as ports. Pin index 5 is port 2, pin index 4 is port 3 and pin index 3 is port 4. `shared_is_port[k]` (k = 0..2, for pin index 3+k) is 1 exactly when s >= 3-k.
- R5: A drive pin that acts as a scan line outputs its drive-level bit. A pin that acts as a port outputs that port's bit. `port1_out` always equals port bit 1.
- R6: `scan_enable` goes to 1 on the first accepted control word. Until then, `key_hit` strobes raise no request.
- R7: While chip-enable is low, `ser_dout` is 0 if a request is pending and 1 otherwise.
- R8: While chip-enable is high during any transfer other than a key read, `ser_dout` is 1, even when a request is pending.
- R9: During a key read, `ser_dout` is 1 before the first rising serial-clock edge. After the n-th rising edge (n = 1..30) it carries key bit n, which is `key_data[n-1]`. After the 31st edge and later it is 1.
- R10: A key read that starts with no request pending shifts out all zeros in slots 1..30 and leaves the request state unchanged.
- R11: A key read that starts with a request pending and sees at least 30 rising edges before chip-enable falls clears the request. A read cut short leaves it pending.
- R12: Transfers behave the same whether the serial clock idles low or high around chip-enable transitions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_ce | input | 1 | Chip-enable: low while the address is clocked, high for the data phase |
| ser_clk | input | 1 | Serial clock, data sampled on its rising edge |
| ser_din | input | 1 | Serial data from the controller |
| ser_dout | output | 1 | Open-drain data-out level (1 = released): read data or active-low request |
| key_hit | input | 1 | One-cycle strobe from the scanner: new key data is stable |
| key_data | input | KEY_BITS | Debounced key vector, bit n-1 is key n |
| drive_pin | output | 6 | Levels on the six drive pins, index 0 is line 1 |
| port1_out | output | 1 | Dedicated general-purpose output 1 |
| shared_is_port | output | 3 | Bit k set when pin 3+k works as a port |
| scan_enable | output | 1 | Scanning allowed, set by the first accepted control word |

## Verification
The bench sweeps every select value against several level patterns, alternating the clock idle polarity. A design that maps the shared pins to the wrong port numbers, or hands them over in the wrong order, produces wrong pin levels. Frames of 15 and 17 bits, frames with a nonzero pad bit, a bit-reversed address and a read address followed by write data must all leave the outputs unchanged. A design that commits on any frame length, or shifts the address MSB first, would change them. Reads are compared slot by slot, including the released slots before key 1 and after key 30, so an off-by-one shift shows at once. A truncated read must keep the request pending, and a read made while the line is high must return zeros without clearing anything. A request raised before the first control word, or a request shown on the line during a write, is also caught.

// File: rtl/kscan_pkg.sv
package kscan_pkg;

  localparam int DRV_N    = 6;   // drive lines, low ones dedicated to scanning
  localparam int SHARED_N = 3;   // top drive lines that may turn into ports
  localparam int PORT_N   = 4;   // general-purpose outputs, port 1 dedicated
  localparam int SEL_W    = 2;
  localparam int FRAME_W  = 16;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2,
    PH_SKIP  = 2'd3
  } phase_t;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [PORT_N-1:0] port;
    logic [DRV_N-1:0]  level;
  } ctrl_t;

  // Field positions inside a 16-bit frame, bit k = k-th bit sent.
  localparam int LVL_LSB  = 0;
  localparam int PORT_LSB = 8;
  localparam int SEL_LSB  = 14;

  function automatic ctrl_t unpack_word(input logic [FRAME_W-1:0] w);
    ctrl_t c;
    c.level = w[LVL_LSB +: DRV_N];
    c.port  = w[PORT_LSB +: PORT_N];
    c.sel   = w[SEL_LSB +: SEL_W];
    return c;
  endfunction

  // Pad positions must be zero for the frame to be accepted.
  function automatic logic pads_clear(input logic [FRAME_W-1:0] w);
    return (w[LVL_LSB+DRV_N +: 2] == 2'b00) && (w[PORT_LSB+PORT_N +: 2] == 2'b00);
  endfunction

  // Shared pin k (drive index DRV_N-SHARED_N+k) is a port when sel >= SHARED_N-k.
  function automatic logic shared_port(input logic [SEL_W-1:0] sel, input int k);
    return int'(sel) >= (SHARED_N - k);
  endfunction

  // Zero-based port bit carried by shared pin k: highest pin carries port 2.
  function automatic int port_index(input int k);
    return SHARED_N - k;
  endfunction

endpackage

// File: rtl/kscan_sync.sv
module kscan_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q
);

  generate
    for (genvar b = 0; b < W; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async[b]};
      end
      assign q[b] = chain[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/kscan_frame.sv
module kscan_frame
  import kscan_pkg::*;
#(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] WR_ADDR  = 8'h62,
  parameter logic [ADDR_W-1:0] RD_ADDR  = 8'h63,
  parameter int                KEY_BITS = 30,
  parameter int                CNT_W    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ce,
  input  logic               sclk,
  input  logic               din,
  output phase_t             phase,
  output logic [CNT_W-1:0]   bit_cnt,
  output logic [FRAME_W-1:0] word,
  output logic               wr_commit,
  output logic               rd_start,
  output logic               rd_finish
);

  localparam int AC_W = $clog2(ADDR_W + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [AC_W-1:0]  ADDR_FULL = AC_W'(ADDR_W);

  logic              ce_d, sclk_d;
  logic              ce_rise, ce_fall, sclk_rise;
  logic [ADDR_W-1:0] addr_sr;
  logic [AC_W-1:0]   addr_cnt;
  phase_t            phase_q, phase_dec;
  logic [CNT_W-1:0]  cnt_q;
  logic [FRAME_W-1:0] word_q;

  assign ce_rise   = ce & ~ce_d;
  assign ce_fall   = ~ce & ce_d;
  assign sclk_rise = sclk & ~sclk_d;

  always_comb begin
    phase_dec = PH_SKIP;
    if (addr_cnt == ADDR_FULL) begin
      if (addr_sr == WR_ADDR)      phase_dec = PH_WRITE;
      else if (addr_sr == RD_ADDR) phase_dec = PH_READ;
    end
  end

  assign wr_commit = ce_fall && (phase_q == PH_WRITE) &&
                     (cnt_q == CNT_W'(FRAME_W)) && pads_clear(word_q);
  assign rd_start  = ce_rise && (phase_dec == PH_READ);
  assign rd_finish = ce_fall && (phase_q == PH_READ) && (cnt_q >= CNT_W'(KEY_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_d     <= 1'b0;
      sclk_d   <= 1'b0;
      addr_sr  <= '0;
      addr_cnt <= '0;
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      word_q   <= '0;
    end else begin
      ce_d   <= ce;
      sclk_d <= sclk;
      if (ce_rise) begin
        phase_q  <= phase_dec;
        cnt_q    <= '0;
        word_q   <= '0;
        addr_cnt <= '0;
      end else if (ce_fall) begin
        phase_q  <= PH_IDLE;
        cnt_q    <= '0;
        addr_cnt <= '0;
      end else if (sclk_rise) begin
        if (!ce) begin
          addr_sr <= {din, addr_sr[ADDR_W-1:1]};
          if (addr_cnt != ADDR_FULL) addr_cnt <= addr_cnt + 1'b1;
        end else begin
          if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          if (phase_q == PH_WRITE) word_q <= {din, word_q[FRAME_W-1:1]};
        end
      end
    end
  end

  assign phase   = phase_q;
  assign bit_cnt = cnt_q;
  assign word    = word_q;

  AST_READ_ONLY_VIA_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_READ && $past(phase_q) != PH_READ) |-> $past(rd_start)); // R2

  AST_NO_DATA_SHIFT_CE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && !ce_d) |=> $stable(word_q)); // R3

endmodule

// File: rtl/kscan_ctrl.sv
module kscan_ctrl
  import kscan_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_commit,
  input  logic [FRAME_W-1:0]  word,
  output logic [DRV_N-1:0]    drive_pin,
  output logic                port1_out,
  output logic [SHARED_N-1:0] shared_is_port,
  output logic                scan_enable
);

  localparam int DED_N = DRV_N - SHARED_N;

  ctrl_t ctrl_q;
  logic  en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
    end else if (wr_commit) begin
      ctrl_q <= unpack_word(word);
      en_q   <= 1'b1;
    end
  end

  generate
    for (genvar i = 0; i < DRV_N; i++) begin : g_pin
      if (i < DED_N) begin : g_scan
        assign drive_pin[i] = ctrl_q.level[i];
      end else begin : g_shared
        localparam int K = i - DED_N;
        assign shared_is_port[K] = shared_port(ctrl_q.sel, K);
        assign drive_pin[i] = shared_is_port[K] ? ctrl_q.port[port_index(K)]
                                                : ctrl_q.level[i];
      end
    end
    for (genvar k = 0; k < SHARED_N - 1; k++) begin : g_thermo
      AST_SHARED_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        shared_is_port[k] |-> shared_is_port[k+1]); // R4
    end
  endgenerate

  assign port1_out   = ctrl_q.port[0];
  assign scan_enable = en_q;

  AST_COMMIT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (ctrl_q == $past(unpack_word(word)))); // R3

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(ctrl_q)); // R3

  AST_PORT1_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> (port1_out == $past(word[PORT_LSB]))); // R5

endmodule

// File: rtl/kscan_request.sv
module kscan_request
  import kscan_pkg::*;
#(
  parameter int KEY_BITS = 30,
  parameter int CNT_W    = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ce,
  input  phase_t              phase,
  input  logic [CNT_W-1:0]    bit_cnt,
  input  logic                rd_start,
  input  logic                rd_finish,
  input  logic                key_hit,
  input  logic [KEY_BITS-1:0] key_data,
  input  logic                scan_enable,
  output logic                dout,
  output logic                req
);

  logic [KEY_BITS-1:0] snap;
  logic                rd_valid, req_q, dout_q, slot_bit;

  // Slot n (1..KEY_BITS) after n rising edges carries key n; others released.
  always_comb begin
    slot_bit = 1'b1;
    for (int n = 1; n <= KEY_BITS; n++) begin
      if (bit_cnt == CNT_W'(n)) slot_bit = snap[n-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      snap     <= '0;
      rd_valid <= 1'b0;
      req_q    <= 1'b0;
      dout_q   <= 1'b1;
    end else begin
      if (rd_start) begin
        snap     <= req_q ? key_data : '0;
        rd_valid <= req_q;
      end
      if (key_hit && scan_enable)     req_q <= 1'b1;
      else if (rd_finish && rd_valid) req_q <= 1'b0;
      if (!ce)                    dout_q <= ~req_q;
      else if (phase == PH_READ)  dout_q <= slot_bit;
      else                        dout_q <= 1'b1;
    end
  end

  assign dout = dout_q;
  assign req  = req_q;

  AST_REQ_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce && req_q) |=> !dout_q); // R7

  AST_RELEASED_NON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && phase != PH_READ) |=> dout_q); // R8

  AST_CLEAR_ONLY_BY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(req_q) |-> $past(rd_finish && rd_valid)); // R11

  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_q) |-> scan_enable); // R6

endmodule

// File: rtl/kscan_serial_if.sv
module kscan_serial_if
  import kscan_pkg::*;
#(
  parameter int         KEY_BITS    = 30,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] WR_ADDR     = 8'h62,
  parameter logic [7:0] RD_ADDR     = 8'h63
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_ce,
  input  logic                ser_clk,
  input  logic                ser_din,
  output logic                ser_dout,
  input  logic                key_hit,
  input  logic [KEY_BITS-1:0] key_data,
  output logic [DRV_N-1:0]    drive_pin,
  output logic                port1_out,
  output logic [SHARED_N-1:0] shared_is_port,
  output logic                scan_enable
);

  localparam int CNT_W = $clog2(KEY_BITS + 3);

  logic [2:0]         synced;
  phase_t             phase;
  logic [CNT_W-1:0]   bit_cnt;
  logic [FRAME_W-1:0] word;
  logic               wr_commit, rd_start, rd_finish, req;

  kscan_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async ({ser_din, ser_clk, ser_ce}),
    .q       (synced)
  );

  kscan_frame #(
    .ADDR_W(8), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR),
    .KEY_BITS(KEY_BITS), .CNT_W(CNT_W)
  ) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce        (synced[0]),
    .sclk      (synced[1]),
    .din       (synced[2]),
    .phase     (phase),
    .bit_cnt   (bit_cnt),
    .word      (word),
    .wr_commit (wr_commit),
    .rd_start  (rd_start),
    .rd_finish (rd_finish)
  );

  kscan_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .wr_commit      (wr_commit),
    .word           (word),
    .drive_pin      (drive_pin),
    .port1_out      (port1_out),
    .shared_is_port (shared_is_port),
    .scan_enable    (scan_enable)
  );

  kscan_request #(.KEY_BITS(KEY_BITS), .CNT_W(CNT_W)) u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce          (synced[0]),
    .phase       (phase),
    .bit_cnt     (bit_cnt),
    .rd_start    (rd_start),
    .rd_finish   (rd_finish),
    .key_hit     (key_hit),
    .key_data    (key_data),
    .scan_enable (scan_enable),
    .dout        (ser_dout),
    .req         (req)
  );

  AST_WRITE_KEEPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req && wr_commit) |=> req); // R11

endmodule

// File: tb/test_kscan_serial_if.sv
module test_kscan_serial_if;

  localparam int KB = 30;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce = 1'b0, sck = 1'b0, din = 1'b0, hit = 1'b0;
  logic [KB-1:0] kd = '0;
  logic          dout, p1, sen;
  logic [5:0]    drv;
  logic [2:0]    shp;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  kscan_serial_if i_kscan_serial_if (
    .clk(clk), .rst_n(rst_n), .ser_ce(ce), .ser_clk(sck), .ser_din(din),
    .ser_dout(dout), .key_hit(hit), .key_data(kd), .drive_pin(drv),
    .port1_out(p1), .shared_is_port(shp), .scan_enable(sen)
  );

  task automatic half();
    repeat (8) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic pulse_hit();
    @(negedge clk); hit = 1'b1;
    @(negedge clk); hit = 1'b0;
  endtask

  task automatic xfer(input logic [7:0] a, input int nb, input logic [31:0] d,
                      input bit ih, output logic [31:0] cap, output logic s0);
    cap = '1;
    sck = ih; ce = 1'b0; half();
    for (int i = 0; i < 8; i++) begin
      sck = 1'b0; din = a[i]; half();
      sck = 1'b1; half();
    end
    if (!ih) begin sck = 1'b0; half(); end
    ce = 1'b1; half();
    s0 = dout;
    for (int i = 0; i < nb; i++) begin
      sck = 1'b0; din = (i < 32) ? d[i] : 1'b0; half();
      sck = 1'b1; half();
      if (i < 32) cap[i] = dout;
    end
    if (!ih) sck = 1'b0;
    half(); ce = 1'b0; half(); half();
  endtask

  // Expected pin levels: s shared pins become ports 2..s+1, port p on pin 7-p.
  function automatic logic [5:0] exp_pins(input logic [5:0] kc, input logic [3:0] pc, input int s);
    logic [5:0] r = kc;
    for (int p = 2; p <= s + 1; p++) r[7-p] = pc[p-1];
    return r;
  endfunction

  function automatic logic [2:0] exp_mask(input int s);
    return 3'(((1 << s) - 1) << (3 - s));
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] cap;
    logic        s0;
    logic [5:0]  lk_drv;
    logic [3:0]  lk_pc;
    logic [2:0]  lk_shp;
    logic [15:0] w;
    logic [KB-1:0] pats [5];
    pats[0] = 30'h2AAA_AAAA; pats[1] = 30'h1555_5555; pats[2] = 30'h0000_0001;
    pats[3] = 30'h2000_0000; pats[4] = 30'h3FFF_FFFF;

    repeat (5) @(negedge clk);
    check("R1 drive in reset", {26'd0, drv}, 32'd0);
    check("R1 port1 in reset", {31'd0, p1}, 32'd0);
    check("R1 mask in reset", {29'd0, shp}, 32'd0);
    check("R1 dout in reset", {31'd0, dout}, 32'd1);
    rst_n = 1'b1; half();
    check("R1 enable after reset", {31'd0, sen}, 32'd0);

    kd = pats[0]; pulse_hit(); half();
    check("R6 request ignored before enable", {31'd0, dout}, 32'd1);

    lk_drv = '0; lk_pc = '0; lk_shp = '0;
    for (int s = 0; s < 4; s++) begin
      for (int v = 0; v < 4; v++) begin
        logic [5:0] kc = 6'(v * 23 + s * 5 + 9);
        logic [3:0] pc = 4'(v * 7 + s * 3 + 5);
        w = {2'(s), 2'b00, pc, 2'b00, kc};
        xfer(8'h62, 16, {16'd0, w}, ((s + v) % 2) == 1, cap, s0);
        check("R4 R5 R12 pin levels", {26'd0, drv}, {26'd0, exp_pins(kc, pc, s)});
        check("R5 port1", {31'd0, p1}, {31'd0, pc[0]});
        check("R4 shared mask", {29'd0, shp}, {29'd0, exp_mask(s)});
        check("R6 enable set", {31'd0, sen}, 32'd1);
        lk_drv = exp_pins(kc, pc, s); lk_pc = pc; lk_shp = exp_mask(s);
      end
    end

    xfer(8'h62, 15, 32'h0000_4000, 1'b0, cap, s0);
    check("R3 15-bit frame dropped", {26'd0, drv}, {26'd0, lk_drv});
    xfer(8'h62, 17, 32'h0001_0000, 1'b1, cap, s0);
    check("R3 17-bit frame dropped", {26'd0, drv}, {26'd0, lk_drv});
    xfer(8'h62, 16, 32'h0000_0040, 1'b0, cap, s0);
    check("R3 pad bit frame dropped", {26'd0, drv}, {26'd0, lk_drv});
    xfer(8'h64, 16, 32'h0000_0000, 1'b0, cap, s0);
    check("R2 wrong address ignored", {26'd0, drv}, {26'd0, lk_drv});
    xfer(8'h46, 16, 32'h0000_0000, 1'b1, cap, s0);
    check("R2 reversed address ignored", {26'd0, drv}, {26'd0, lk_drv});
    xfer(8'h63, 16, 32'h0000_0000, 1'b0, cap, s0);
    check("R2 read address writes nothing", {26'd0, drv}, {26'd0, lk_drv});
    check("R2 read address port1", {31'd0, p1}, {31'd0, lk_pc[0]});
    check("R2 read address mask", {29'd0, shp}, {29'd0, lk_shp});

    for (int t = 0; t < 5; t++) begin
      kd = pats[t]; pulse_hit(); half();
      check("R7 request shown", {31'd0, dout}, 32'd0);
      xfer(8'h63, 32, 32'd0, (t % 2) == 1, cap, s0);
      check("R9 slot before first edge", {31'd0, s0}, 32'd1);
      check("R9 R12 key slots", cap, {2'b11, pats[t]});
      check("R11 request cleared", {31'd0, dout}, 32'd1);
    end

    kd = '1;
    xfer(8'h63, 32, 32'd0, 1'b0, cap, s0);
    check("R10 read without request", cap, {2'b11, 30'd0});
    check("R10 request stays clear", {31'd0, dout}, 32'd1);

    kd = pats[1]; pulse_hit(); half();
    xfer(8'h63, 20, 32'd0, 1'b1, cap, s0);
    check("R11 short read keeps request", {31'd0, dout}, 32'd0);
    xfer(8'h62, 16, {16'd0, 2'(3), 2'b00, 4'hA, 2'b00, 6'h05}, 1'b0, cap, s0);
    check("R8 released during write", {31'd0, s0}, 32'd1);
    check("R7 write keeps request", {31'd0, dout}, 32'd0);
    xfer(8'h63, 30, 32'd0, 1'b0, cap, s0);
    check("R11 30-edge read clears", {31'd0, dout}, 32'd1);

    kd = pats[2]; pulse_hit(); half();
    rst_n = 1'b0; repeat (3) @(negedge clk);
    check("R1 mid reset drive", {26'd0, drv}, 32'd0);
    check("R1 mid reset mask", {29'd0, shp}, 32'd0);
    check("R1 mid reset dout", {31'd0, dout}, 32'd1);
    check("R1 mid reset enable", {31'd0, sen}, 32'd0);
    rst_n = 1'b1; half();
    check("R1 no request after reset", {31'd0, dout}, 32'd1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule